// File: doc/BRIEF.md
# Dual-Mode ADC Host Read Controller

This block sits between a processor-side request/response port and a parallel analog-to-digital converter. The converter has active-low chip-select and read strobes, an active-low BUSY output that stays low while a conversion runs, and a 12-bit parallel result bus. Driving both strobes low together starts a conversion. A conversion that is already running cannot be restarted.

A one-bit mode input is sampled when a request is accepted. In stalling mode, a single read starts a conversion. The strobes are then held low until BUSY has gone low and come back high, and the fresh result is returned. In pipelined mode, the strobes are pulsed for a fixed number of clocks. Each such read returns whatever result the converter already holds, which is the previous conversion, and starts the next one. Pipelined reads are kept apart by a programmable number of idle cycles so that each conversion can finish. A request that arrives too early is held, not lost. Each returned word comes with a one-cycle done pulse and a flag that marks whether the data is meaningful.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `adc_cs_n_o` and `adc_rd_n_o` are 1, and `rsp_valid_o` and `busy_o` are 0.
- R2: The two strobes always carry the same level. They fall together in the cycle after a request is accepted, or after the gap stall ends.
- R3: With `mode_i`=0 at acceptance (stalling mode), the strobes stay low until the synchronized BUSY input has been seen low and then high again. They are released on the clock edge at which high is seen.
- R4: A stalling-mode read returns the 12-bit word from its own conversion, with `rsp_ok_o`=1. The value the bus carries while BUSY is low, which is the older result, is never returned.
- R5: With `mode_i`=1 at acceptance (pipelined mode), the strobes are low for exactly `RD_W` cycles (default 3). The bus is captured on the last of those cycles.
- R6: A pipelined read returns the result the converter held before that read, which is the previous conversion. `rsp_ok_o` is 0 when no transaction has completed since reset, and 1 otherwise.
- R7: After a pipelined read, the strobes stay high for at least max(`gap_i`,1) cycles before the next pipelined read. The count is exactly `gap_i` when the next request is already waiting. A request that arrives during the gap is held and then performed.
- R8: `rsp_valid_o` is a single-cycle pulse. It rises on the edge that releases the strobes. `rsp_data_o` and `rsp_ok_o` hold their values between pulses.
- R9: `busy_o` is 1 from the edge that accepts a request until the edge that raises `rsp_valid_o`. Requests that arrive while `busy_o` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, sampled only while idle |
| mode_i | input | 1 | 0 = stalling read, 1 = pipelined read; sampled with the request |
| gap_i | input | GAP_W | Minimum released cycles between pipelined reads |
| busy_o | output | 1 | Transaction in progress |
| rsp_valid_o | output | 1 | One-cycle done pulse |
| rsp_data_o | output | DATA_W | Returned conversion word |
| rsp_ok_o | output | 1 | Returned word is a real conversion result |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| adc_busy_n_i | input | 1 | Converter BUSY, low while converting |
| adc_data_i | input | DATA_W | Converter parallel result bus |

## Verification
The bench runs stalling-mode reads across a range of converter conversion lengths. A controller that captured before BUSY rose again would return the stale bus value instead of the new conversion word. It also sweeps the pipelined gap over several values, issuing each request the moment the previous one completes. An off-by-one gap counter would show up as a released interval one cycle too short or too long. The first pipelined read after reset must be flagged invalid, and a pipelined read that follows a stalling read must return that stalling read's word. A second request pulsed in the middle of a transaction must produce neither an extra strobe nor an extra done pulse.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_GAP    = 3'd1,
      ST_NW_STB = 3'd2,
      ST_WS_LO  = 3'd3,
      ST_WS_HI  = 3'd4
   } rd_state_e;

   localparam logic MODE_WAIT = 1'b0;
   localparam logic MODE_PIPE = 1'b1;

endpackage

// File: rtl/adc_rd_sync.sv
`timescale 1ns/1ps
module adc_rd_sync #(
   parameter int STAGES   = 2,
   parameter bit RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adc_rd_gap.sv
`timescale 1ns/1ps
module adc_rd_gap #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [GAP_W-1:0] gap_i,
   output logic             ready_o
);

   logic [GAP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= gap_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - GAP_W'(1);
   end

   // ready one cycle early: the strobe falls on the edge after ready is seen
   assign ready_o = (cnt_q[GAP_W-1:1] == '0);

endmodule

// File: rtl/adc_rd_fsm.sv
`timescale 1ns/1ps
module adc_rd_fsm
   import adc_rd_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int RD_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              mode_i,
   input  logic              gap_ready_i,
   input  logic              busy_n_s_i,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              txn_o,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              ok_o,
   output logic              gap_load_o
);

   localparam int CNT_W = (RD_W > 2) ? $clog2(RD_W) : 1;

   rd_state_e         st_q, st_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              mode_q, mode_d;
   logic              primed_q;
   logic              fin;
   logic              done_q, ok_q;
   logic [DATA_W-1:0] data_q;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      mode_d = mode_q;
      fin    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_i) begin
               mode_d = mode_i;
               if (mode_i == MODE_WAIT) begin
                  st_d = ST_WS_LO;
               end else if (gap_ready_i) begin
                  st_d  = ST_NW_STB;
                  cnt_d = CNT_W'(RD_W - 1);
               end else begin
                  st_d = ST_GAP;
               end
            end
         end
         ST_GAP: begin
            if (gap_ready_i) begin
               st_d  = ST_NW_STB;
               cnt_d = CNT_W'(RD_W - 1);
            end
         end
         ST_NW_STB: begin
            if (cnt_q == '0) begin
               st_d = ST_IDLE;
               fin  = 1'b1;
            end else begin
               cnt_d = cnt_q - CNT_W'(1);
            end
         end
         ST_WS_LO: begin
            if (!busy_n_s_i) st_d = ST_WS_HI;
         end
         ST_WS_HI: begin
            if (busy_n_s_i) begin
               st_d = ST_IDLE;
               fin  = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         mode_q   <= MODE_WAIT;
         primed_q <= 1'b0;
         done_q   <= 1'b0;
         ok_q     <= 1'b0;
         data_q   <= '0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         mode_q <= mode_d;
         done_q <= fin;
         if (fin) begin
            data_q   <= adc_data_i;
            ok_q     <= (mode_q == MODE_WAIT) | primed_q;
            primed_q <= 1'b1;
         end
      end
   end

   logic strobe;
   assign strobe     = (st_q == ST_NW_STB) || (st_q == ST_WS_LO) || (st_q == ST_WS_HI);
   assign cs_n_o     = ~strobe;
   assign rd_n_o     = ~strobe;
   assign txn_o      = (st_q != ST_IDLE);
   assign done_o     = done_q;
   assign data_o     = data_q;
   assign ok_o       = ok_q;
   assign gap_load_o = fin && (mode_q == MODE_PIPE);

endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl #(
   parameter int DATA_W      = 12,
   parameter int RD_W        = 3,
   parameter int GAP_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              mode_i,
   input  logic [GAP_W-1:0]  gap_i,
   output logic              busy_o,
   output logic              rsp_valid_o,
   output logic [DATA_W-1:0] rsp_data_o,
   output logic              rsp_ok_o,
   output logic              adc_cs_n_o,
   output logic              adc_rd_n_o,
   input  logic              adc_busy_n_i,
   input  logic [DATA_W-1:0] adc_data_i
);

   generate
      if (DATA_W < 1)                        begin : g_bad_dw  $error("DATA_W must be positive"); end
      if (RD_W < 2)                          begin : g_bad_rw  $error("RD_W must be at least 2"); end
      if (GAP_W < 2)                         begin : g_bad_gw  $error("GAP_W must be at least 2"); end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_ss $error("SYNC_STAGES out of range"); end
   endgenerate

   logic busy_n_s;
   logic gap_ready;
   logic gap_load;

   adc_rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (adc_busy_n_i),
      .q_o   (busy_n_s)
   );

   adc_rd_gap #(.GAP_W(GAP_W)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (gap_load),
      .gap_i   (gap_i),
      .ready_o (gap_ready)
   );

   adc_rd_fsm #(.DATA_W(DATA_W), .RD_W(RD_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .mode_i      (mode_i),
      .gap_ready_i (gap_ready),
      .busy_n_s_i  (busy_n_s),
      .adc_data_i  (adc_data_i),
      .cs_n_o      (adc_cs_n_o),
      .rd_n_o      (adc_rd_n_o),
      .txn_o       (busy_o),
      .done_o      (rsp_valid_o),
      .data_o      (rsp_data_o),
      .ok_o        (rsp_ok_o),
      .gap_load_o  (gap_load)
   );

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
`timescale 1ns/1ps
module adc_rd_ctrl_chk #(
   parameter int DATA_W = 12,
   parameter int RD_W   = 3,
   parameter int GAP_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              mode_i,
   input logic [GAP_W-1:0]  gap_i,
   input logic              busy_o,
   input logic              rsp_valid_o,
   input logic [DATA_W-1:0] rsp_data_o,
   input logic              adc_cs_n_o,
   input logic              adc_rd_n_o,
   input logic              adc_busy_n_i
);

   logic             c_mode, seen_lo, last_pipe;
   logic [7:0]       lo_cnt;
   logic [GAP_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_mode    <= 1'b0;
         seen_lo   <= 1'b0;
         last_pipe <= 1'b0;
         lo_cnt    <= '0;
         hi_cnt    <= '0;
      end else begin
         if (!busy_o && req_i) begin
            c_mode  <= mode_i;
            seen_lo <= 1'b0;
         end else if (!adc_cs_n_o && !adc_busy_n_i) begin
            seen_lo <= 1'b1;
         end
         if (rsp_valid_o) last_pipe <= c_mode;
         if (!adc_cs_n_o) lo_cnt <= (lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1;
         else             lo_cnt <= '0;
         if (!adc_cs_n_o)          hi_cnt <= '0;
         else if (hi_cnt != '1)    hi_cnt <= hi_cnt + GAP_W'(1);
      end
   end

   AST_STB_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n_o) |-> $fell(adc_rd_n_o)); // R2

   AST_WS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(adc_cs_n_o) && !c_mode) |-> (seen_lo && adc_busy_n_i)); // R3

   AST_NW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(adc_cs_n_o) && c_mode) |-> (lo_cnt == 8'(RD_W))); // R5

   AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adc_cs_n_o) && c_mode && last_pipe) |-> (hi_cnt >= gap_i)); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |=> !rsp_valid_o); // R8

   AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> (adc_cs_n_o && !$past(adc_cs_n_o))); // R8

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid_o |-> $stable(rsp_data_o)); // R8

   AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && req_i) |=> busy_o); // R9

   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> rsp_valid_o); // R9

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
   .DATA_W (DATA_W),
   .RD_W   (RD_W),
   .GAP_W  (GAP_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .mode_i       (mode_i),
   .gap_i        (gap_i),
   .busy_o       (busy_o),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_data_o   (rsp_data_o),
   .adc_cs_n_o   (adc_cs_n_o),
   .adc_rd_n_o   (adc_rd_n_o),
   .adc_busy_n_i (adc_busy_n_i)
);

// File: tb/sim_adc_rd_ctrl.sv
`timescale 1ns/1ps
module sim_adc_rd_ctrl;

   localparam int DW = 12;
   localparam int RW = 3;
   localparam int GW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          mode = 1'b0;
   logic [GW-1:0] gap = '0;
   logic          busy, rsp_valid, rsp_ok, cs_n, rd_n;
   logic [DW-1:0] rsp_data;
   logic          busy_n_m = 1'b1;
   logic [DW-1:0] bus_m = '0;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   adc_rd_ctrl #(.DATA_W(DW), .RD_W(RW), .GAP_W(GW), .SYNC_STAGES(2)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req),
      .mode_i       (mode),
      .gap_i        (gap),
      .busy_o       (busy),
      .rsp_valid_o  (rsp_valid),
      .rsp_data_o   (rsp_data),
      .rsp_ok_o     (rsp_ok),
      .adc_cs_n_o   (cs_n),
      .adc_rd_n_o   (rd_n),
      .adc_busy_n_i (busy_n_m),
      .adc_data_i   (bus_m)
   );

   function automatic logic [DW-1:0] fval(input int n);
      return DW'((n * 389 + 77) % 4096);
   endfunction

   // converter model: starts on the falling combined strobe, cannot restart
   int   conv_len = 4;
   int   n_conv = 0;
   int   left = 0;
   logic stb_q = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         left <= 0; busy_n_m <= 1'b1; stb_q <= 1'b0;
      end else begin
         stb_q <= !cs_n && !rd_n;
         if (left == 0) begin
            if (!cs_n && !rd_n && !stb_q) begin
               left <= conv_len; busy_n_m <= 1'b0; n_conv <= n_conv + 1;
            end
         end else if (left == 1) begin
            left <= 0; busy_n_m <= 1'b1; bus_m <= fval(n_conv);
         end else begin
            left <= left - 1;
         end
      end
   end

   // strobe monitor
   int   run = 0, lo_len = 0, hi_len = 0, n_fall = 0, n_done = 0, n_mismatch = 0;
   logic cs_prev = 1'b1;
   always @(negedge clk) begin
      if (cs_n !== rd_n) n_mismatch++;
      if (cs_n !== cs_prev) begin
         if (cs_n) lo_len = run;
         else begin hi_len = run; n_fall++; end
         run = 1;
      end else run++;
      cs_prev = cs_n;
      if (rsp_valid) n_done++;
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_ge(input string tag, input int act, input int lim);
      n_chk++;
      if (act < lim) begin
         n_err++;
         $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
      end
   endtask

   task automatic do_read(input logic m, output logic [DW-1:0] d, output logic ok);
      mode = m; req = 1'b1;
      @(negedge clk); req = 1'b0;
      chk("R9 busy after accept", int'(busy), 1);
      while (!rsp_valid) @(negedge clk);
      d = rsp_data; ok = rsp_ok;
      chk("R8 strobe released with done", int'(cs_n), 1);
      chk("R9 busy ends with done", int'(busy), 0);
      @(negedge clk);
      chk("R8 done one cycle", int'(rsp_valid), 0);
      chk("R8 data held", int'(rsp_data), int'(d));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      logic          ok;
      logic [DW-1:0] prev;
      int            fd, dd;

      repeat (4) @(negedge clk);
      chk("R1 cs_n in reset", int'(cs_n), 1);
      chk("R1 rd_n in reset", int'(rd_n), 1);
      chk("R1 valid in reset", int'(rsp_valid), 0);
      chk("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cs_n after reset", int'(cs_n), 1);
      chk("R1 busy after reset", int'(busy), 0);

      // first pipelined read: unprimed
      conv_len = RW + 1; gap = 8'd3;
      do_read(1'b1, d, ok);
      chk("R6 first read flagged invalid", int'(ok), 0);
      chk("R5 pipelined strobe width", lo_len, RW);
      repeat (16) @(negedge clk);
      do_read(1'b1, d, ok);
      chk("R6 second read valid", int'(ok), 1);
      chk("R6 second read returns previous", int'(d), int'(fval(1)));

      // gap sweep, second request raised as soon as the first completes
      for (int g = 2; g <= 9; g++) begin
         gap = GW'(g);
         repeat (16) @(negedge clk);
         do_read(1'b1, d, ok);
         prev = fval(n_conv);
         do_read(1'b1, d, ok);
         chk($sformatf("R7 released gap g=%0d", g), hi_len, g);
         chk($sformatf("R6 pipelined data g=%0d", g), int'(d), int'(prev));
         chk($sformatf("R5 strobe width g=%0d", g), lo_len, RW);
      end

      // stalling mode across conversion lengths
      for (int l = 1; l <= 8; l++) begin
         conv_len = l;
         repeat (8) @(negedge clk);
         prev = bus_m;
         do_read(1'b0, d, ok);
         chk($sformatf("R4 own result L=%0d", l), int'(d), int'(fval(n_conv)));
         chk($sformatf("R4 ok flag L=%0d", l), int'(ok), 1);
         n_chk++;
         if (d == prev) begin
            n_err++;
            $display("FAIL R4 stale word returned L=%0d actual=%0d expected!=%0d", l, d, prev);
         end
         chk_ge($sformatf("R3 strobes held through BUSY L=%0d", l), lo_len, l + 2);
      end

      // pipelined after stalling returns the stalling result
      conv_len = RW + 1;
      prev = fval(n_conv);
      repeat (16) @(negedge clk);
      do_read(1'b1, d, ok);
      chk("R6 pipelined after stalling", int'(d), int'(prev));
      chk("R6 ok after stalling", int'(ok), 1);

      // requests during a transaction are ignored
      repeat (16) @(negedge clk);
      fd = n_fall; dd = n_done;
      mode = 1'b1; req = 1'b1;
      @(negedge clk); req = 1'b0;
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
      while (!rsp_valid) @(negedge clk);
      repeat (30) @(negedge clk);
      chk("R9 single strobe for overlapped request", n_fall - fd, 1);
      chk("R9 single done for overlapped request", n_done - dd, 1);
      chk("R9 idle afterwards", int'(busy), 0);

      chk("R2 strobes never differ", n_mismatch, 0);

      summary();
      $finish;
   end

endmodule